// File: doc/BRIEF.md
# Scoreboard Dynamic Issue Controller

This block is the control core of an out-of-order floating-point pipeline that keeps issue in program order. Each cycle it may accept one decoded instruction, given as an operation class, a destination register and two source registers. It assigns the instruction to one of five functional-unit slots: integer, first multiplier, second multiplier, adder and divider. It then decides when that slot may read its operands from the register file and when it may write its result back. The block tracks three kinds of state. For each unit it holds a status entry: destination, sources, the producing unit of each source, and a ready flag per source. For each register it holds the unit that will write it. Each slot also runs its own lifecycle state machine. There is no operand forwarding. A source counts as ready only once its producer has written the register file.

Each slot runs the states `SL_IDLE`, `SL_OPWAIT`, `SL_EXEC` and `SL_WBWAIT`, with these transitions:

- *issue*: `SL_IDLE` to `SL_OPWAIT`, on a handshake steered to the slot.
- *read*: `SL_OPWAIT` to `SL_EXEC`, when both source flags are ready; `rd_grant` is high in that cycle.
- *done*: `SL_EXEC` to `SL_WBWAIT`, on a `fu_done` pulse.
- *write*: `SL_WBWAIT` to `SL_IDLE`, when `wr_grant` is high.

A write clears the register's result entry. It also wakes every slot that was waiting on the writing unit.

The execution units sit outside the block. Each one pulses its `fu_done` bit when its result is ready. The register file performs a read when it sees `rd_grant` and a write when it sees `wr_grant`.

Top module: `sb_scoreboard`

## Requirements
- R1: Class code 0 steers to unit 0 (integer), code 2 to unit 3 (adder) and code 3 to unit 4 (divider). Code 1 steers to unit 1 if that unit is idle, otherwise to unit 2. `iss_grant` is one-hot with bit i meaning unit i, and it is high only in the cycle the handshake completes.
- R2: `in_ready` is low while the steered-to unit is busy (structural stall).
- R3: `in_ready` is low while any active instruction already targets the same destination register (WAW stall).
- R4: No issue occurs in a cycle with `in_valid` or `in_ready` low, so a stalled instruction blocks all later ones.
- R5: `rd_grant[i]` is high only while both sources of unit i have no pending producer. It comes no earlier than the cycle after issue, and exactly once per issued instruction.
- R6: When a producer writes, every slot waiting on that producer becomes ready, and its read grant can appear in the next cycle.
- R7: `fu_done[i]` has no effect unless unit i is executing. A unit requests its write in the cycle after an accepted done pulse.
- R8: A unit is refused `wr_grant` while another unit still waits to read a source that equals the first unit's destination and is flagged ready. The grant follows once that read has happened.
- R9: At most one `wr_grant` bit is high per cycle. Among eligible units the lowest index wins.
- R10: A unit written in cycle N accepts a new issue in cycle N+1, and the register it wrote no longer blocks that issue.
- R11: An instruction issued in the same cycle that its source's producer writes treats that source as ready.
- R12: After reset all units are idle, no grant is high, and `in_ready` is high for any instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Instruction can issue this cycle |
| in_class | input | 2 | Operation class: 0 integer, 1 multiply, 2 add, 3 divide |
| in_dst | input | 5 | Destination register number |
| in_src1 | input | 5 | First source register number |
| in_src2 | input | 5 | Second source register number |
| fu_done | input | 5 | Per-unit execution-complete pulse |
| iss_grant | output | 5 | One-hot unit that took the issue |
| rd_grant | output | 5 | Per-unit operand read permission |
| wr_grant | output | 5 | Per-unit result write permission |

## Verification
The properties assume the instruction source holds a stalled instruction until `in_ready` rises. They also assume each unit pulses `fu_done` only after it has been granted its read. The stimulus pulses `fu_done` only toward units that are executing, with one deliberate exception: a pulse to a unit still waiting for operands. That pulse checks that a stray done has no effect, which the design must ignore. Every instruction in the stimulus is valid for a single cycle, and any instruction that is refused is either a deliberate stall probe or is presented again later as a fresh instruction.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int NUM_FU = 5;
    localparam int FU_W   = 3;

    typedef logic [FU_W-1:0] fu_id_t;

    localparam fu_id_t FU_INT  = 3'd0;
    localparam fu_id_t FU_MUL1 = 3'd1;
    localparam fu_id_t FU_MUL2 = 3'd2;
    localparam fu_id_t FU_ADD  = 3'd3;
    localparam fu_id_t FU_DIV  = 3'd4;
    localparam fu_id_t NO_FU   = 3'd7;

    typedef enum logic [1:0] {
        OPC_INT = 2'd0,
        OPC_MUL = 2'd1,
        OPC_ADD = 2'd2,
        OPC_DIV = 2'd3
    } op_class_e;

    typedef enum logic [1:0] {
        SL_IDLE   = 2'd0,
        SL_OPWAIT = 2'd1,
        SL_EXEC   = 2'd2,
        SL_WBWAIT = 2'd3
    } slot_state_e;
endpackage

// File: rtl/sb_issue_steer.sv
module sb_issue_steer
    import sb_pkg::*;
(
    input  logic [1:0]        cls,
    input  logic [NUM_FU-1:0] unit_busy,
    input  logic              dst_pending,
    output fu_id_t            tgt_id,
    output logic [NUM_FU-1:0] tgt_onehot,
    output logic              accept
);
    op_class_e cls_e;

    always_comb begin
        cls_e = op_class_e'(cls);
        unique case (cls_e)
            OPC_INT: tgt_id = FU_INT;
            OPC_MUL: tgt_id = unit_busy[FU_MUL1] ? FU_MUL2 : FU_MUL1;
            OPC_ADD: tgt_id = FU_ADD;
            OPC_DIV: tgt_id = FU_DIV;
            default: tgt_id = FU_INT;
        endcase
    end

    always_comb begin
        tgt_onehot = '0;
        for (int u = 0; u < NUM_FU; u++) begin
            if (tgt_id == fu_id_t'(u)) tgt_onehot[u] = 1'b1;
        end
        accept = ((tgt_onehot & unit_busy) == '0) && !dst_pending;
    end
endmodule

// File: rtl/sb_result_table.sv
module sb_result_table
    import sb_pkg::*;
#(
    parameter int NREG = 32,
    parameter int RW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [RW-1:0] set_reg,
    input  fu_id_t        set_fu,
    input  logic          clr_en,
    input  logic [RW-1:0] clr_reg,
    input  fu_id_t        clr_fu,
    input  logic [RW-1:0] rd_dst,
    input  logic [RW-1:0] rd_s1,
    input  logic [RW-1:0] rd_s2,
    output logic          dst_pending,
    output fu_id_t        q_s1,
    output fu_id_t        q_s2
);
    fu_id_t tab [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) tab[r] <= NO_FU;
        end else begin
            if (clr_en) tab[clr_reg] <= NO_FU;
            if (set_en) tab[set_reg] <= set_fu;
        end
    end

    // A producer writing this cycle no longer counts as pending for a new reader.
    always_comb begin
        dst_pending = (tab[rd_dst] != NO_FU);
        q_s1 = tab[rd_s1];
        q_s2 = tab[rd_s2];
        if (clr_en && q_s1 == clr_fu) q_s1 = NO_FU;
        if (clr_en && q_s2 == clr_fu) q_s2 = NO_FU;
    end
endmodule

// File: rtl/sb_unit_slot.sv
module sb_unit_slot
    import sb_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_go,
    input  logic [RW-1:0] iss_dst,
    input  logic [RW-1:0] iss_src1,
    input  logic [RW-1:0] iss_src2,
    input  fu_id_t        iss_q1,
    input  fu_id_t        iss_q2,
    input  logic          done_in,
    input  logic          wb_go,
    input  logic          wr_any,
    input  fu_id_t        wr_id,
    output logic          busy,
    output logic          rd_req,
    output logic          wb_req,
    output logic [RW-1:0] fi,
    output logic [RW-1:0] fj,
    output logic [RW-1:0] fk,
    output logic          rj,
    output logic          rk
);
    slot_state_e st, st_nxt;
    fu_id_t      qj, qk;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= SL_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            SL_IDLE:   if (iss_go)  st_nxt = SL_OPWAIT;
            SL_OPWAIT: if (rj && rk) st_nxt = SL_EXEC;
            SL_EXEC:   if (done_in) st_nxt = SL_WBWAIT;
            SL_WBWAIT: if (wb_go)   st_nxt = SL_IDLE;
            default:                st_nxt = SL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fi <= '0;
            fj <= '0;
            fk <= '0;
            qj <= NO_FU;
            qk <= NO_FU;
            rj <= 1'b0;
            rk <= 1'b0;
        end else if (st == SL_IDLE && iss_go) begin
            fi <= iss_dst;
            fj <= iss_src1;
            fk <= iss_src2;
            qj <= iss_q1;
            qk <= iss_q2;
            rj <= (iss_q1 == NO_FU);
            rk <= (iss_q2 == NO_FU);
        end else if (st == SL_OPWAIT) begin
            if (rj && rk) begin
                rj <= 1'b0;
                rk <= 1'b0;
            end else begin
                if (wr_any && qj == wr_id) begin
                    qj <= NO_FU;
                    rj <= 1'b1;
                end
                if (wr_any && qk == wr_id) begin
                    qk <= NO_FU;
                    rk <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        busy   = (st != SL_IDLE);
        rd_req = (st == SL_OPWAIT) && rj && rk;
        wb_req = (st == SL_WBWAIT);
    end
endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter
    import sb_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic [NUM_FU-1:0]         wb_req,
    input  logic [NUM_FU-1:0][RW-1:0] fi,
    input  logic [NUM_FU-1:0][RW-1:0] fj,
    input  logic [NUM_FU-1:0][RW-1:0] fk,
    input  logic [NUM_FU-1:0]         rj,
    input  logic [NUM_FU-1:0]         rk,
    output logic [NUM_FU-1:0]         wr_grant,
    output logic                      wr_any,
    output fu_id_t                    wr_id,
    output logic [RW-1:0]             wr_reg
);
    logic [NUM_FU-1:0] war_free;
    logic [NUM_FU-1:0] eligible;

    always_comb begin
        for (int u = 0; u < NUM_FU; u++) begin
            war_free[u] = 1'b1;
            for (int f = 0; f < NUM_FU; f++) begin
                if (f != u) begin
                    if (rj[f] && fj[f] == fi[u]) war_free[u] = 1'b0;
                    if (rk[f] && fk[f] == fi[u]) war_free[u] = 1'b0;
                end
            end
        end
        eligible = wb_req & war_free;
    end

    always_comb begin
        wr_grant = '0;
        wr_any   = 1'b0;
        wr_id    = NO_FU;
        wr_reg   = '0;
        for (int u = NUM_FU - 1; u >= 0; u--) begin
            if (eligible[u]) begin
                wr_grant = '0;
                wr_grant[u] = 1'b1;
                wr_any   = 1'b1;
                wr_id    = fu_id_t'(u);
                wr_reg   = fi[u];
            end
        end
    end
endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard
    import sb_pkg::*;
#(
    parameter int NREG = 32,
    parameter int RW   = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_class,
    input  logic [RW-1:0]     in_dst,
    input  logic [RW-1:0]     in_src1,
    input  logic [RW-1:0]     in_src2,
    input  logic [NUM_FU-1:0] fu_done,
    output logic [NUM_FU-1:0] iss_grant,
    output logic [NUM_FU-1:0] rd_grant,
    output logic [NUM_FU-1:0] wr_grant
);
    logic [NUM_FU-1:0]         unit_busy;
    logic [NUM_FU-1:0]         wb_req;
    logic [NUM_FU-1:0]         rj_v, rk_v;
    logic [NUM_FU-1:0][RW-1:0] fi_a, fj_a, fk_a;
    fu_id_t                    tgt_id, q1, q2, wr_id;
    logic [NUM_FU-1:0]         tgt_onehot;
    logic                      dst_pending, accept, wr_any, iss_fire;
    logic [RW-1:0]             wr_reg;

    sb_issue_steer u_steer (
        .cls         (in_class),
        .unit_busy   (unit_busy),
        .dst_pending (dst_pending),
        .tgt_id      (tgt_id),
        .tgt_onehot  (tgt_onehot),
        .accept      (accept)
    );

    assign in_ready  = accept;
    assign iss_fire  = in_valid && accept;
    assign iss_grant = iss_fire ? tgt_onehot : '0;

    sb_result_table #(.NREG(NREG), .RW(RW)) u_rtab (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_en      (iss_fire),
        .set_reg     (in_dst),
        .set_fu      (tgt_id),
        .clr_en      (wr_any),
        .clr_reg     (wr_reg),
        .clr_fu      (wr_id),
        .rd_dst      (in_dst),
        .rd_s1       (in_src1),
        .rd_s2       (in_src2),
        .dst_pending (dst_pending),
        .q_s1        (q1),
        .q_s2        (q2)
    );

    for (genvar g = 0; g < NUM_FU; g++) begin : g_slot
        sb_unit_slot #(.RW(RW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .iss_go   (iss_grant[g]),
            .iss_dst  (in_dst),
            .iss_src1 (in_src1),
            .iss_src2 (in_src2),
            .iss_q1   (q1),
            .iss_q2   (q2),
            .done_in  (fu_done[g]),
            .wb_go    (wr_grant[g]),
            .wr_any   (wr_any),
            .wr_id    (wr_id),
            .busy     (unit_busy[g]),
            .rd_req   (rd_grant[g]),
            .wb_req   (wb_req[g]),
            .fi       (fi_a[g]),
            .fj       (fj_a[g]),
            .fk       (fk_a[g]),
            .rj       (rj_v[g]),
            .rk       (rk_v[g])
        );
    end

    sb_wb_arbiter #(.RW(RW)) u_arb (
        .wb_req   (wb_req),
        .fi       (fi_a),
        .fj       (fj_a),
        .fk       (fk_a),
        .rj       (rj_v),
        .rk       (rk_v),
        .wr_grant (wr_grant),
        .wr_any   (wr_any),
        .wr_id    (wr_id),
        .wr_reg   (wr_reg)
    );
endmodule

// File: rtl/sb_checker.sv
module sb_checker
    import sb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [NUM_FU-1:0] iss_grant,
    input logic [NUM_FU-1:0] rd_grant,
    input logic [NUM_FU-1:0] wr_grant
);
    a_r9_wr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_grant));

    a_r1_iss_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(iss_grant));

    a_r4_iss_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_grant != '0) |-> (in_valid && in_ready));

    a_r5_rd_once: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_grant != '0) |=> ((rd_grant & $past(rd_grant)) == '0));

    a_r7_wr_once: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_grant != '0) |=> ((wr_grant & $past(wr_grant)) == '0));

    a_r2_iss_idle_unit: assert property (@(posedge clk) disable iff (!rst_n)
        ((iss_grant & (rd_grant | wr_grant)) == '0));
endmodule

bind sb_scoreboard sb_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .iss_grant (iss_grant),
    .rd_grant  (rd_grant),
    .wr_grant  (wr_grant)
);

// File: tb/sb_scoreboard_bench.sv
module sb_scoreboard_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [1:0] in_class = '0;
    logic [4:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic [4:0] fu_done = '0;
    logic [4:0] iss_grant, rd_grant, wr_grant;

    int errors = 0;
    int checks = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    sb_scoreboard u_sb_scoreboard (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_class(in_class), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .fu_done(fu_done), .iss_grant(iss_grant), .rd_grant(rd_grant), .wr_grant(wr_grant)
    );

    // valid, class, dst, src1, src2, exp_ready, exp_iss, exp_rd
    localparam int VW = 29;
    localparam logic [VW-1:0] VEC [10] = '{
        {1'b1, 2'd2, 5'd8,  5'd6,  5'd2,  1'b1, 5'b01000, 5'b00000},
        {1'b1, 2'd1, 5'd0,  5'd2,  5'd4,  1'b1, 5'b00010, 5'b01000},
        {1'b1, 2'd1, 5'd10, 5'd0,  5'd6,  1'b1, 5'b00100, 5'b00010},
        {1'b1, 2'd1, 5'd12, 5'd1,  5'd1,  1'b0, 5'b00000, 5'b00000},
        {1'b1, 2'd3, 5'd0,  5'd3,  5'd3,  1'b0, 5'b00000, 5'b00000},
        {1'b1, 2'd0, 5'd20, 5'd21, 5'd22, 1'b1, 5'b00001, 5'b00000},
        {1'b1, 2'd2, 5'd1,  5'd2,  5'd3,  1'b0, 5'b00000, 5'b00001},
        {1'b1, 2'd3, 5'd2,  5'd0,  5'd8,  1'b1, 5'b10000, 5'b00000},
        {1'b0, 2'd0, 5'd30, 5'd0,  5'd0,  1'b0, 5'b00000, 5'b00000},
        {1'b0, 2'd3, 5'd31, 5'd0,  5'd0,  1'b0, 5'b00000, 5'b00000}
    };

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(logic v, logic [1:0] c, logic [4:0] d, logic [4:0] a,
                       logic [4:0] b, logic [4:0] dn);
        @(negedge clk);
        in_valid = v; in_class = c; in_dst = d; in_src1 = a; in_src2 = b;
        fu_done = dn;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; in_valid = 0; fu_done = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        do_reset();
        // R12: reset state
        cyc(0, 2'd0, 5'd0, 5'd0, 5'd0, 5'b0);
        chk("R12 ready", {31'b0, in_ready}, 1);
        chk("R12 grants", {17'b0, iss_grant, rd_grant, wr_grant}, 0);

        // R1 R2 R3 R4 R5: table walk
        for (int i = 0; i < 10; i++) begin
            logic [VW-1:0] e;
            e = VEC[i];
            cyc(e[28], e[27:26], e[25:21], e[20:16], e[15:11], 5'b0);
            chk($sformatf("R2/R3 ready v%0d", i), {31'b0, in_ready}, {31'b0, e[10]});
            chk($sformatf("R1/R4 iss v%0d", i), {27'b0, iss_grant}, {27'b0, e[9:5]});
            chk($sformatf("R5 rd v%0d", i), {27'b0, rd_grant}, {27'b0, e[4:0]});
        end

        // R9: integer and adder finish together; integer wins first
        cyc(0, 2'd0, 5'd0, 5'd0, 5'd0, 5'b01001);
        chk("R7 no wr at done", {27'b0, wr_grant}, 0);
        cyc(1, 2'd0, 5'd20, 5'd5, 5'd5, 5'b0);
        chk("R9 int first", {27'b0, wr_grant}, 5'b00001);
        chk("R10 not yet free", {31'b0, in_ready}, 0);
        cyc(1, 2'd0, 5'd20, 5'd5, 5'd5, 5'b0);
        chk("R9 add second", {27'b0, wr_grant}, 5'b01000);
        chk("R10 reissue", {27'b0, iss_grant}, 5'b00001);
        cyc(0, 2'd0, 5'd0, 5'd0, 5'd0, 5'b00010);
        chk("R5 int reads", {27'b0, rd_grant}, 5'b00001);
        // R11: add issues reading F0 while first multiplier writes F0
        cyc(1, 2'd2, 5'd9, 5'd0, 5'd0, 5'b0);
        chk("R11 mul1 write", {27'b0, wr_grant}, 5'b00010);
        chk("R11 issue", {27'b0, iss_grant}, 5'b01000);
        cyc(0, 2'd0, 5'd0, 5'd0, 5'd0, 5'b0);
        chk("R6 R11 wake reads", {27'b0, rd_grant}, 5'b11100);

        // R8 WAR scenario from a fresh reset
        do_reset();
        cyc(1, 2'd1, 5'd4, 5'd1, 5'd1, 5'b0);
        chk("R1 mul1", {27'b0, iss_grant}, 5'b00010);
        cyc(1, 2'd2, 5'd6, 5'd4, 5'd2, 5'b0);
        chk("R5 mul1 reads", {27'b0, rd_grant}, 5'b00010);
        cyc(1, 2'd3, 5'd2, 5'd3, 5'd3, 5'b01000); // stray done to waiting adder
        chk("R1 div", {27'b0, iss_grant}, 5'b10000);
        chk("R5 add waits", {27'b0, rd_grant}, 0);
        cyc(0, 2'd0, 5'd0, 5'd0, 5'd0, 5'b0);
        chk("R5 div reads", {27'b0, rd_grant}, 5'b10000);
        cyc(0, 2'd0, 5'd0, 5'd0, 5'd0, 5'b10000);
        chk("R8 none yet", {27'b0, wr_grant}, 0);
        cyc(0, 2'd0, 5'd0, 5'd0, 5'd0, 5'b00010);
        chk("R8 div held", {27'b0, wr_grant}, 0);
        cyc(0, 2'd0, 5'd0, 5'd0, 5'd0, 5'b0);
        chk("R8 mul1 passes", {27'b0, wr_grant}, 5'b00010);
        cyc(0, 2'd0, 5'd0, 5'd0, 5'd0, 5'b0);
        chk("R6 add reads", {27'b0, rd_grant}, 5'b01000);
        chk("R8 div still held", {27'b0, wr_grant}, 0);
        cyc(0, 2'd0, 5'd0, 5'd0, 5'd0, 5'b0);
        chk("R8 div released", {27'b0, wr_grant}, 5'b10000);
        cyc(0, 2'd0, 5'd0, 5'd0, 5'd0, 5'b0);
        chk("R7 stray done ignored", {27'b0, wr_grant}, 0);
        cyc(0, 2'd0, 5'd0, 5'd0, 5'd0, 5'b0);
        chk("R7 stray done ignored 2", {27'b0, wr_grant}, 0);

        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule